// File: doc/BRIEF.md
# Dual-Channel Prescaled Pulse-Width Modulator

The block produces two independent pulse-width modulated outputs. Software reaches it through a small synchronous register port. A single control word carries packed per-channel settings: a prescaler code, an enable, an active-level choice and a clock gate. Each channel also has its own word that holds the period length and the number of active ticks.

Each channel divides the core clock by a ratio picked from a fixed, non-linear table. The divided ticks drive an 8-bit counter that runs from zero up to the programmed period value and then wraps. A new period/duty value is held pending and is taken up only when the running period ends, so no output period is ever cut short. While an update is pending, a read-only busy flag in the control word is set, and further writes to that channel's period word are dropped.

Top module: `dual_pwm_timer`

## Requirements
- R1: After reset the control word, both period words and both busy flags read as zero, and both outputs sit high, because an active-level bit of 0 gives inverted polarity and an idle channel drives its inactive level.
- R2: The control word at address 0x0 stores bits [9:0] for channel 0 and bits [24:15] for channel 1 (channel n at a left shift of 15×n). All other bits read as zero except the busy flags at bit 28 (channel 0) and bit 29 (channel 1), which writes cannot change.
- R3: Within a channel's field, bits [3:0] pick the divide ratio: 0→120, 1→180, 2→240, 3→360, 4→480, 8→12000, 9→24000, 10→36000, 11→48000, 12→72000, 15→1. Codes 5, 6, 7, 13 and 14 stop the channel's counter and force its inactive level.
- R4: A running channel counts prescaled ticks from 0 to P, so one period is (P+1)×ratio clock cycles. It drives its active level while the count is below D and the inactive level otherwise: D=0 never goes active, and D>P stays active all the time.
- R5: Field bit 5 set makes high the active level; bit 5 clear makes low the active level, and the inactive level is always the opposite.
- R6: A channel runs only when its enable (field bit 4) and clock gate (field bit 6) are both set. Otherwise it drives its inactive level and holds its tick divider and period counter at zero, so it restarts from count 0.
- R7: Channel n's period word sits at address 0x4+4×n, with P in bits [23:16] and D in bits [7:0]. A read returns the last accepted value, with all other bits zero.
- R8: An accepted write to a period word sets that channel's busy flag. The new P and D take effect, and the flag clears, at the clock edge where the running period wraps, or at the next edge if the channel is idle.
- R9: A write to a period word while that channel's busy flag is set is ignored.
- R10: Field bits 7, 8 and 9 are stored and read back but have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_addr | input | 4 | Byte address of the register being accessed |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pwm_out | output | 2 | One PWM output per channel |

## Verification
A wrong divider or counter state shows up in the per-cycle output comparison within one prescaled tick. That is a single clock cycle when the divide-by-1 code is selected, and at most one full period for the longer ratios. A wrong pending or busy state is visible at once on a read of the control word. It also appears at the output at the next period wrap, where the new period length would start too early or too late. The exact-period tests measure active time over whole periods, so an off-by-one in the wrap or duty compare changes the count directly.

// File: rtl/pwm2_pkg.sv
package pwm2_pkg;
  // width of the tick divider counter, large enough for the biggest ratio
  localparam int PS_W = 17;
  // bit positions inside one channel's control field
  localparam int FLD_W    = 10;
  localparam int B_EN     = 4;
  localparam int B_ACT_HI = 5;
  localparam int B_GATE   = 6;

  // divide ratio per prescaler code; zero marks a reserved code
  function automatic logic [PS_W-1:0] code_to_div(input logic [3:0] code);
    case (code)
      4'd0:    code_to_div = PS_W'(120);
      4'd1:    code_to_div = PS_W'(180);
      4'd2:    code_to_div = PS_W'(240);
      4'd3:    code_to_div = PS_W'(360);
      4'd4:    code_to_div = PS_W'(480);
      4'd8:    code_to_div = PS_W'(12000);
      4'd9:    code_to_div = PS_W'(24000);
      4'd10:   code_to_div = PS_W'(36000);
      4'd11:   code_to_div = PS_W'(48000);
      4'd12:   code_to_div = PS_W'(72000);
      4'd15:   code_to_div = PS_W'(1);
      default: code_to_div = '0;
    endcase
  endfunction
endpackage

// File: rtl/pwm_tick_div.sv
module pwm_tick_div
  import pwm2_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run_req,
  input  logic [3:0] code,
  output logic       code_ok,
  output logic       tick
);
  logic [PS_W-1:0] div;
  logic [PS_W-1:0] pc_q, pc_d;
  logic            active;

  assign div     = code_to_div(code);
  assign code_ok = (div != '0);
  assign active  = run_req && code_ok;
  assign tick    = active && (pc_q >= div - 1'b1);

  always_comb begin
    pc_d = pc_q;
    if (!active || tick) pc_d = '0;
    else                 pc_d = pc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end

  // R3
  stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !code_ok |=> (pc_q == '0));
endmodule

// File: rtl/pwm_lane.sv
module pwm_lane
  import pwm2_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_req,
  input  logic [3:0]       code,
  input  logic             act_hi,
  input  logic             wr_req,
  input  logic [CNT_W-1:0] wr_prd,
  input  logic [CNT_W-1:0] wr_dty,
  output logic             busy,
  output logic [CNT_W-1:0] pend_prd,
  output logic [CNT_W-1:0] pend_dty,
  output logic             pwm_o
);
  logic             code_ok, tick, run, wrap, take, accept;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] act_prd_q, act_prd_d, act_dty_q, act_dty_d;
  logic [CNT_W-1:0] pend_prd_q, pend_prd_d, pend_dty_q, pend_dty_d;
  logic             busy_q, busy_d;

  pwm_tick_div u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_req (run_req),
    .code    (code),
    .code_ok (code_ok),
    .tick    (tick)
  );

  assign run    = run_req && code_ok;
  assign wrap   = tick && (cnt_q >= act_prd_q);
  assign take   = busy_q && (!run || wrap);
  assign accept = wr_req && !busy_q;

  always_comb begin
    cnt_d      = cnt_q;
    act_prd_d  = act_prd_q;
    act_dty_d  = act_dty_q;
    pend_prd_d = pend_prd_q;
    pend_dty_d = pend_dty_q;
    busy_d     = busy_q;
    if (!run)      cnt_d = '0;
    else if (wrap) cnt_d = '0;
    else if (tick) cnt_d = cnt_q + 1'b1;
    if (take) begin
      act_prd_d = pend_prd_q;
      act_dty_d = pend_dty_q;
      busy_d    = 1'b0;
    end
    if (accept) begin
      pend_prd_d = wr_prd;
      pend_dty_d = wr_dty;
      busy_d     = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      act_prd_q  <= '0;
      act_dty_q  <= '0;
      pend_prd_q <= '0;
      pend_dty_q <= '0;
      busy_q     <= 1'b0;
    end else begin
      cnt_q      <= cnt_d;
      act_prd_q  <= act_prd_d;
      act_dty_q  <= act_dty_d;
      pend_prd_q <= pend_prd_d;
      pend_dty_q <= pend_dty_d;
      busy_q     <= busy_d;
    end
  end

  assign busy     = busy_q;
  assign pend_prd = pend_prd_q;
  assign pend_dty = pend_dty_q;
  assign pwm_o    = (run && (cnt_q < act_dty_q)) ? act_hi : !act_hi;

  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= act_prd_q);
  // R6
  idle_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_req |=> (cnt_q == '0));
  // R8
  hold_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && busy_q && !tick) |=> busy_q);
  // R9
  drop_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && busy_q) |=> ($stable(pend_prd_q) && $stable(pend_dty_q)));
endmodule

// File: rtl/dual_pwm_timer.sv
module dual_pwm_timer
  import pwm2_pkg::*;
#(
  parameter int NUM_CH   = 2,
  parameter int CNT_W    = 8,
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32,
  parameter int STRIDE   = 15,
  parameter int RDY_BASE = 28,
  parameter int PRD_LSB  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NUM_CH-1:0] pwm_out
);
  function automatic logic [DATA_W-1:0] make_mask();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int c = 0; c < NUM_CH; c++) m[STRIDE*c +: FLD_W] = '1;
    return m;
  endfunction
  localparam logic [DATA_W-1:0] CTRL_MASK = make_mask();

  logic [DATA_W-1:0] ctrl_q, ctrl_d;
  logic [NUM_CH-1:0] busy;
  logic [CNT_W-1:0]  pend_prd [NUM_CH];
  logic [CNT_W-1:0]  pend_dty [NUM_CH];
  logic              ctrl_wr;

  assign ctrl_wr = bus_we && (bus_addr == '0);

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_wr) ctrl_d = bus_wdata & CTRL_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_lane
    logic wr_req;
    assign wr_req = bus_we && (bus_addr == ADDR_W'(4 + 4*ch));
    pwm_lane #(.CNT_W(CNT_W)) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .run_req  (ctrl_q[STRIDE*ch + B_EN] && ctrl_q[STRIDE*ch + B_GATE]),
      .code     (ctrl_q[STRIDE*ch +: 4]),
      .act_hi   (ctrl_q[STRIDE*ch + B_ACT_HI]),
      .wr_req   (wr_req),
      .wr_prd   (bus_wdata[PRD_LSB +: CNT_W]),
      .wr_dty   (bus_wdata[CNT_W-1:0]),
      .busy     (busy[ch]),
      .pend_prd (pend_prd[ch]),
      .pend_dty (pend_dty[ch]),
      .pwm_o    (pwm_out[ch])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == '0) begin
      bus_rdata = ctrl_q;
      bus_rdata[RDY_BASE +: NUM_CH] = busy;
    end
    for (int ch = 0; ch < NUM_CH; ch++) begin
      if (bus_addr == ADDR_W'(4 + 4*ch)) begin
        bus_rdata[PRD_LSB +: CNT_W] = pend_prd[ch];
        bus_rdata[CNT_W-1:0]        = pend_dty[ch];
      end
    end
  end

  // R2
  ctrl_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> $stable(ctrl_q));
endmodule

// File: tb/dual_pwm_timer_test.sv
`timescale 1ns/1ps
module dual_pwm_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  baddr;
  logic        bwe;
  logic [31:0] bwdata;
  logic [31:0] brdata;
  logic [1:0]  pout;
  int          checks = 0;
  int          fails = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  dual_pwm_timer uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(baddr), .bus_we(bwe),
    .bus_wdata(bwdata), .bus_rdata(brdata), .pwm_out(pout)
  );

  localparam logic [31:0] CMASK = 32'h01FF_83FF;

  // behavioural reference state
  logic [31:0] m_ctrl;
  int          m_cnt [2], m_pc [2], m_aprd [2], m_adty [2], m_pprd [2], m_pdty [2];
  bit          m_busy [2];

  function automatic int ref_div(int code);
    case (code)
      0: return 120;    1: return 180;    2: return 240;
      3: return 360;    4: return 480;    8: return 12000;
      9: return 24000;  10: return 36000; 11: return 48000;
      12: return 72000; 15: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic bit ref_run(int ch);
    logic [31:0] f;
    f = m_ctrl >> (15*ch);
    return f[4] && f[6] && (ref_div(int'(f[3:0])) != 0);
  endfunction

  function automatic logic ref_out(int ch);
    logic [31:0] f;
    f = m_ctrl >> (15*ch);
    if (ref_run(ch) && (m_cnt[ch] < m_adty[ch])) return f[5];
    return !f[5];
  endfunction

  function automatic logic [31:0] ref_rd(int a);
    if (a == 0) return m_ctrl | (32'(m_busy[0]) << 28) | (32'(m_busy[1]) << 29);
    if (a == 4) return (32'(m_pprd[0]) << 16) | 32'(m_pdty[0]);
    if (a == 8) return (32'(m_pprd[1]) << 16) | 32'(m_pdty[1]);
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 32'h0;
      for (int ch = 0; ch < 2; ch++) begin
        m_cnt[ch] = 0; m_pc[ch] = 0; m_aprd[ch] = 0; m_adty[ch] = 0;
        m_pprd[ch] = 0; m_pdty[ch] = 0; m_busy[ch] = 0;
      end
    end else begin
      for (int ch = 0; ch < 2; ch++) begin
        bit b, tk;
        int d;
        logic [31:0] f;
        f  = m_ctrl >> (15*ch);
        d  = ref_div(int'(f[3:0]));
        b  = m_busy[ch];
        if (!ref_run(ch)) begin
          m_cnt[ch] = 0; m_pc[ch] = 0;
          if (b) begin
            m_aprd[ch] = m_pprd[ch]; m_adty[ch] = m_pdty[ch]; m_busy[ch] = 0;
          end
        end else begin
          tk = (m_pc[ch] >= d - 1);
          m_pc[ch] = tk ? 0 : m_pc[ch] + 1;
          if (tk) begin
            if (m_cnt[ch] >= m_aprd[ch]) begin
              m_cnt[ch] = 0;
              if (b) begin
                m_aprd[ch] = m_pprd[ch]; m_adty[ch] = m_pdty[ch]; m_busy[ch] = 0;
              end
            end else m_cnt[ch] = m_cnt[ch] + 1;
          end
        end
        if (bwe && (int'(baddr) == 4 + 4*ch) && !b) begin
          m_pprd[ch] = int'(bwdata[23:16]);
          m_pdty[ch] = int'(bwdata[7:0]);
          m_busy[ch] = 1;
        end
      end
      if (bwe && baddr == 4'h0) m_ctrl = bwdata & CMASK;
    end
  end

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-cycle output comparison against the reference
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int ch = 0; ch < 2; ch++)
        chk(pout[ch] == ref_out(ch), "R4/R5 per-cycle output", pout[ch], ref_out(ch));
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bwe = 1'b1; baddr = a; bwdata = d;
    @(negedge clk);
    bwe = 1'b0;
  endtask

  task automatic rd_chk(input logic [3:0] a, input logic [31:0] exp, input string tag);
    baddr = a;
    #1;
    chk(brdata == exp, tag, brdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_level(input int ch, input logic lvl, input int n, output int cnt);
    cnt = 0;
    repeat (n) begin
      @(negedge clk);
      if (pout[ch] == lvl) cnt++;
    end
  endtask

  initial begin
    int k;
    bwe = 1'b0; baddr = 4'h0; bwdata = 32'h0;
    idle(3);
    rst_n = 1'b1;
    // R1 reset state
    rd_chk(4'h0, 32'h0, "R1 control after reset");
    rd_chk(4'h4, 32'h0, "R1 period0 after reset");
    rd_chk(4'h8, 32'h0, "R1 period1 after reset");
    chk(pout == 2'b11, "R1 outputs idle high", pout, 2'b11);

    // R7 / R8 update while idle
    wr(4'h4, 32'h0004_0002);
    rd_chk(4'h0, 32'h1000_0000, "R8 busy set after write");
    rd_chk(4'h4, 32'h0004_0002, "R7 period0 readback");
    idle(1);
    rd_chk(4'h0, 32'h0, "R8 idle channel takes value next edge");
    wr(4'h8, 32'hFF02_FF01);
    rd_chk(4'h8, 32'h0002_0001, "R7 period1 readback, other bits zero");
    idle(2);

    // R2 layout: ch0 div1 en act-high gate, ch1 div1 en act-low gate
    wr(4'h0, 32'h002F_807F);
    rd_chk(4'h0, 32'h002F_807F, "R2 control readback");
    idle(10);
    count_level(0, 1'b1, 15, k);
    chk(k == 6, "R4 active ticks over three periods", k, 6);
    count_level(1, 1'b0, 15, k);
    chk(k == 5, "R5 inverted channel low ticks", k, 5);

    // R3 ratio 120 on ch0, R9 dropped rewrite
    wr(4'h0, 32'h002F_8070);
    wr(4'h4, 32'h0007_0003);
    rd_chk(4'h0, 32'h102F_8070, "R8 busy while running");
    wr(4'h4, 32'h0001_0000);
    rd_chk(4'h4, 32'h0007_0003, "R9 write while busy ignored");
    idle(700);
    rd_chk(4'h0, 32'h002F_8070, "R8 busy cleared at wrap");
    count_level(0, 1'b1, 960, k);
    chk(k == 360, "R3 ratio 120 active cycles per period", k, 360);

    // R10 stored but inert bits on ch1
    wr(4'h0, 32'h01EF_8070);
    rd_chk(4'h0, 32'h01EF_8070, "R10 inert bits read back");
    count_level(1, 1'b0, 9, k);
    chk(k == 3, "R10 output unchanged by inert bits", k, 3);

    // R4 duty corners on ch1 (active low)
    wr(4'h8, 32'h0002_0005);
    idle(6);
    count_level(1, 1'b0, 6, k);
    chk(k == 6, "R4 duty above period stays active", k, 6);
    wr(4'h8, 32'h0002_0000);
    idle(6);
    count_level(1, 1'b0, 6, k);
    chk(k == 0, "R4 zero duty never active", k, 0);

    // R3 reserved codes on ch0 (act-high, inactive low)
    wr(4'h4, 32'h0001_0001);
    wr(4'h0, 32'h01EF_8075);
    idle(2);
    count_level(0, 1'b1, 20, k);
    chk(k == 0, "R3 reserved code 5 holds inactive", k, 0);
    wr(4'h0, 32'h01EF_807D);
    idle(2);
    count_level(0, 1'b1, 20, k);
    chk(k == 0, "R3 reserved code 13 holds inactive", k, 0);
    rd_chk(4'h0, ref_rd(0), "R3 control readback with reserved code");

    // R6 enable or gate alone
    wr(4'h0, 32'h01EF_803F);
    idle(2);
    count_level(0, 1'b1, 10, k);
    chk(k == 0, "R6 enable without gate is idle", k, 0);
    wr(4'h0, 32'h01EF_806F);
    idle(2);
    count_level(0, 1'b1, 10, k);
    chk(k == 0, "R6 gate without enable is idle", k, 0);
    wr(4'h0, 32'h01EF_807F);
    count_level(0, 1'b1, 10, k);
    chk(k == 5, "R6 restart from count zero", k, 5);

    // R2 reserved bits and busy flags are not writable
    wr(4'h0, 32'hFFFF_FFFF);
    rd_chk(4'h0, ref_rd(0), "R2 mask and read-only busy");
    chk(ref_rd(0) == CMASK, "R2 expected masked value", ref_rd(0), CMASK);
    idle(20);
    wr(4'h0, 32'h0);
    idle(3);
    chk(pout == 2'b11, "R5 inverted idle level after clear", pout, 2'b11);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule